// File: doc/BRIEF.md
# Conditional Flow and Stack Sequencer

This block settles where a 16-bit processor goes next after a control-transfer or stack instruction. It takes the instruction class from the decoder, together with a condition mask, a condition value, the live status flags, the program counter, the immediate word and the contents of the chosen stack register. It then runs a short state machine that works out the new program counter and the new stack-register value. Where the instruction needs memory, it issues one stack write or one stack read.

A condition passes when the flags, masked by the care mask, equal the wanted value. Any flag can therefore be ignored, and a zero mask makes the transfer unconditional. Any general register can act as the stack pointer, and it moves in steps of two bytes. The stack grows downward: a decrement comes before a write, and a read comes before an increment. The program-counter input is the address that follows the immediate word. Relative targets are computed from it, calls save it, and an untaken transfer simply continues from it.

States: `S_IDLE` waits for `start`. `S_DECIDE` latches nothing new and computes the results; from there a jump or branch goes to `S_FINISH`, a call or push goes to `S_WRITE`, and a return or pop goes to `S_READ`. `S_WRITE` stores to the decremented address and then goes to `S_FINISH`. `S_READ` requests the word at the stack address and goes to `S_CAPTURE`. `S_CAPTURE` takes the returned word and goes to `S_FINISH`. `S_FINISH` raises `done` and returns to `S_IDLE`.

Top module: `flow_stack_seq`

## Requirements
- R1: A jump or branch is taken exactly when (flags AND care_mask) equals want_flags, so a care_mask of 0 always takes it.
- R2: Bit 2 of flags, care_mask and want_flags is carry, bit 1 is zero and bit 0 is negative.
- R3: The op_class codes are 0 jump, 1 branch, 2 call-absolute, 3 call-relative, 4 return, 5 push, 6 pop and 7 reserved. A taken jump gives pc_out = imm. A taken branch gives pc_out = pc_in + imm, modulo 2^16.
- R4: An untaken jump or branch, and op_class 7, give pc_out = pc_in. They make no memory request and leave sp_we and dst_we low.
- R5: A call ignores the condition and writes pc_in to address sp_in-2. It then reports sp_out = sp_in-2 with sp_we high, and pc_out = imm (code 2) or pc_in+imm (code 3).
- R6: A return reads the word at address sp_in and gives pc_out = that word and sp_out = sp_in+2, with sp_we high.
- R7: A push writes src_data to address sp_in-2 and gives sp_out = sp_in-2 with sp_we high, and pc_out = pc_in.
- R8: A pop reads the word at address sp_in and gives dst_data = that word with dst_we high, sp_out = sp_in+2 and pc_out = pc_in.
- R9: done is a one-cycle pulse. It comes 2 cycles after the start edge for codes 0, 1 and 7, 3 cycles for calls and pushes, and 4 cycles for returns and pops. start is ignored while busy is high.
- R10: After reset, done, busy, mem_req, sp_we and dst_we are 0, and pc_out and sp_out are 0.
- R11: Stack addresses wrap modulo 2^16, so a push with sp_in = 0 writes address 0xFFFE.
- R12: Memory read data is taken on mem_rdata in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the current inputs |
| op_class | input | 3 | Instruction class code |
| care_mask | input | 3 | Flags taking part in the condition |
| want_flags | input | 3 | Required values of the cared flags |
| flags | input | 3 | Status flags {carry, zero, negative} |
| pc_in | input | 16 | Address following the immediate word |
| imm | input | 16 | Immediate word |
| sp_in | input | 16 | Current stack-register value |
| src_data | input | 16 | Register value to push |
| mem_rdata | input | 16 | Read data, one cycle after request |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address of the stack word |
| mem_wdata | output | 16 | Write data |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack-register value |
| sp_we | output | 1 | Write sp_out back, valid with done |
| dst_data | output | 16 | Popped word |
| dst_we | output | 1 | Write dst_data back, valid with done |
| done | output | 1 | Results valid this cycle |

## Verification
Each operation takes a fixed number of cycles: two for jumps and branches, three for calls and pushes, four for returns and pops, all counted from the clock edge that samples start. The bench raises start at a falling edge and then counts falling edges until done is seen. It compares that count with the expected latency for the instruction class, and it reads pc_out, sp_out and the write-enables at that same falling edge, where they are stable. Memory is modelled with a one-cycle read, so stack contents are checked in the bench's own memory once done has been seen. A second start during a busy call checks that the latched operation still completes and that done pulses only once.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int WORD_W = 16;
    localparam int FLAG_W = 3;

    typedef enum logic [2:0] {
        OPC_JUMP     = 3'd0,
        OPC_BRANCH   = 3'd1,
        OPC_CALL_ABS = 3'd2,
        OPC_CALL_REL = 3'd3,
        OPC_RETURN   = 3'd4,
        OPC_PUSH     = 3'd5,
        OPC_POP      = 3'd6,
        OPC_RSVD     = 3'd7
    } op_class_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECIDE,
        S_WRITE,
        S_READ,
        S_CAPTURE,
        S_FINISH
    } seq_state_t;
endpackage

// File: rtl/flow_cond.sv
module flow_cond #(
    parameter int FLAG_W = 3
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] care_mask,
    input  logic [FLAG_W-1:0] want_flags,
    output logic              pass
);
    logic [FLAG_W-1:0] bit_ok;

    for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
        assign bit_ok[g] = !care_mask[g] || (flags[g] == want_flags[g]);
    end

    assign pass = &bit_ok;
endmodule

// File: rtl/flow_target.sv
module flow_target #(
    parameter int WORD_W = 16
) (
    input  flow_pkg::op_class_t op,
    input  logic                pass,
    input  logic [WORD_W-1:0]   pc,
    input  logic [WORD_W-1:0]   imm,
    output logic [WORD_W-1:0]   next_pc
);
    import flow_pkg::*;

    always_comb begin
        unique case (op)
            OPC_JUMP:     next_pc = pass ? imm : pc;
            OPC_BRANCH:   next_pc = pass ? pc + imm : pc;
            OPC_CALL_ABS: next_pc = imm;
            OPC_CALL_REL: next_pc = pc + imm;
            default:      next_pc = pc;
        endcase
    end
endmodule

// File: rtl/flow_stack_seq.sv
module flow_stack_seq #(
    parameter int WORD_W  = flow_pkg::WORD_W,
    parameter int FLAG_W  = flow_pkg::FLAG_W,
    parameter int SP_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_class,
    input  logic [FLAG_W-1:0] care_mask,
    input  logic [FLAG_W-1:0] want_flags,
    input  logic [FLAG_W-1:0] flags,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] imm,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [WORD_W-1:0] src_data,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] sp_out,
    output logic              sp_we,
    output logic [WORD_W-1:0] dst_data,
    output logic              dst_we,
    output logic              done
);
    import flow_pkg::*;

    localparam logic [WORD_W-1:0] STEP = WORD_W'(SP_STEP);

    seq_state_t state_q, state_d;

    op_class_t         op_q;
    logic [FLAG_W-1:0] care_q, want_q, flags_q;
    logic [WORD_W-1:0] pc_q, imm_q, sp_q, src_q;
    logic [WORD_W-1:0] pc_res, sp_res, dst_res;

    logic              cond_pass;
    logic [WORD_W-1:0] target_pc;
    logic              is_call, is_write, is_read;

    assign is_call  = (op_q == OPC_CALL_ABS) || (op_q == OPC_CALL_REL);
    assign is_write = is_call || (op_q == OPC_PUSH);
    assign is_read  = (op_q == OPC_RETURN) || (op_q == OPC_POP);

    flow_cond #(.FLAG_W(FLAG_W)) i_cond (
        .flags      (flags_q),
        .care_mask  (care_q),
        .want_flags (want_q),
        .pass       (cond_pass)
    );

    flow_target #(.WORD_W(WORD_W)) i_target (
        .op      (op_q),
        .pass    (cond_pass),
        .pc      (pc_q),
        .imm     (imm_q),
        .next_pc (target_pc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_DECIDE;
            S_DECIDE:  state_d = is_write ? S_WRITE : (is_read ? S_READ : S_FINISH);
            S_WRITE:   state_d = S_FINISH;
            S_READ:    state_d = S_CAPTURE;
            S_CAPTURE: state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Operand latch and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OPC_JUMP;
            care_q  <= '0;
            want_q  <= '0;
            flags_q <= '0;
            pc_q    <= '0;
            imm_q   <= '0;
            sp_q    <= '0;
            src_q   <= '0;
            pc_res  <= '0;
            sp_res  <= '0;
            dst_res <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    op_q    <= op_class_t'(op_class);
                    care_q  <= care_mask;
                    want_q  <= want_flags;
                    flags_q <= flags;
                    pc_q    <= pc_in;
                    imm_q   <= imm;
                    sp_q    <= sp_in;
                    src_q   <= src_data;
                end
                S_DECIDE: begin
                    pc_res <= target_pc;
                    if (is_write)     sp_res <= sp_q - STEP;
                    else if (is_read) sp_res <= sp_q + STEP;
                    else              sp_res <= sp_q;
                end
                S_CAPTURE: begin
                    if (op_q == OPC_RETURN) pc_res  <= mem_rdata;
                    else                    dst_res <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        mem_req   = (state_q == S_WRITE) || (state_q == S_READ);
        mem_we    = (state_q == S_WRITE);
        mem_addr  = (state_q == S_WRITE) ? sp_res : sp_q;
        mem_wdata = is_call ? pc_q : src_q;
        done      = (state_q == S_FINISH);
        sp_we     = done && (is_write || is_read);
        dst_we    = done && (op_q == OPC_POP);
        pc_out    = pc_res;
        sp_out    = sp_res;
        dst_data  = dst_res;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(sp_q) && $stable(pc_q)); // R9
    AST_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_addr == sp_q - STEP); // R5
    AST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> mem_addr == sp_q); // R6
    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (sp_out == sp_q - STEP) || (sp_out == sp_q + STEP)); // R7
    AST_POP_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> sp_out == sp_q + STEP); // R8
    AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OPC_JUMP && cond_pass) |-> pc_out == imm_q); // R3
    AST_FLOW_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_q == OPC_JUMP || op_q == OPC_BRANCH)) |-> !mem_req); // R4
endmodule

// File: tb/test_flow_stack_seq.sv
module test_flow_stack_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_class = '0, care_mask = '0, want_flags = '0, flags = '0;
    logic [15:0] pc_in = '0, imm = '0, sp_in = '0, src_data = '0;
    logic [15:0] mem_rdata;
    logic        busy, mem_req, mem_we, sp_we, dst_we, done;
    logic [15:0] mem_addr, mem_wdata, pc_out, sp_out, dst_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] mem [256];
    logic mem_seen;

    always #2 clk = ~clk;

    flow_stack_seq i_flow_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
        .care_mask(care_mask), .want_flags(want_flags), .flags(flags),
        .pc_in(pc_in), .imm(imm), .sp_in(sp_in), .src_data(src_data),
        .mem_rdata(mem_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_out(pc_out),
        .sp_out(sp_out), .sp_we(sp_we), .dst_data(dst_data), .dst_we(dst_we),
        .done(done)
    );

    // Stack memory: one-cycle read (R12)
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[8:1]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[8:1]];
    end

    always @(negedge clk) if (mem_req) mem_seen <= 1'b1;

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [2:0] cm, input logic [2:0] wf,
                          input logic [2:0] fl, input logic [15:0] pc, input logic [15:0] im,
                          input logic [15:0] sp, input logic [15:0] src, output int lat);
        @(negedge clk);
        op_class = op; care_mask = cm; want_flags = wf; flags = fl;
        pc_in = pc; imm = im; sp_in = sp; src_data = src;
        mem_seen = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // {op, care, want, flags, pc, imm, expected pc}
    localparam logic [59:0] VEC [9] = '{
        {3'd0, 3'b000, 3'b000, 3'b000, 16'h0102, 16'h4000, 16'h4000},
        {3'd0, 3'b010, 3'b010, 3'b010, 16'h0102, 16'h4000, 16'h4000},
        {3'd0, 3'b010, 3'b010, 3'b101, 16'h0102, 16'h4000, 16'h0102},
        {3'd1, 3'b100, 3'b000, 3'b011, 16'h1000, 16'hFFF0, 16'h0FF0},
        {3'd1, 3'b100, 3'b100, 3'b011, 16'h1000, 16'hFFF0, 16'h1000},
        {3'd1, 3'b001, 3'b001, 3'b001, 16'h2000, 16'h0010, 16'h2010},
        {3'd0, 3'b111, 3'b101, 3'b101, 16'h0300, 16'h1234, 16'h1234},
        {3'd0, 3'b111, 3'b101, 3'b111, 16'h0300, 16'h1234, 16'h0300},
        {3'd7, 3'b000, 3'b000, 3'b000, 16'h0500, 16'h9999, 16'h0500}
    };

    initial begin
        int lat;
        int dones;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 done", {15'd0, done}, 16'd0);
        chk("R10 busy", {15'd0, busy}, 16'd0);
        chk("R10 mem_req", {15'd0, mem_req}, 16'd0);
        chk("R10 we", {14'd0, sp_we, dst_we}, 16'd0);
        chk("R10 pc_out", pc_out, 16'd0);
        chk("R10 sp_out", sp_out, 16'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 flow vectors
        for (int i = 0; i < 9; i++) begin
            run_op(VEC[i][59:57], VEC[i][56:54], VEC[i][53:51], VEC[i][50:48],
                   VEC[i][47:32], VEC[i][31:16], 16'h0040, 16'h0, lat);
            chk("R1 R2 R3 R4 pc_out", pc_out, VEC[i][15:0]);
            chk("R9 flow latency", 16'(lat), 16'd2);
            chk("R4 no stack effect", {13'd0, mem_seen, sp_we, dst_we}, 16'd0);
        end

        // R5 call absolute, condition ignored
        run_op(3'd2, 3'b111, 3'b000, 3'b111, 16'h0124, 16'h0800, 16'h0100, 16'h0, lat);
        chk("R5 call-abs pc", pc_out, 16'h0800);
        chk("R5 call-abs sp", sp_out, 16'h00FE);
        chk("R5 call-abs sp_we", {15'd0, sp_we}, 16'd1);
        chk("R9 call latency", 16'(lat), 16'd3);
        @(negedge clk);
        chk("R9 done pulse", {15'd0, done}, 16'd0);
        chk("R5 saved pc", mem[8'h7F], 16'h0124);

        // R5 call relative
        run_op(3'd3, 3'b000, 3'b000, 3'b000, 16'h0200, 16'h0040, 16'h00FE, 16'h0, lat);
        chk("R5 call-rel pc", pc_out, 16'h0240);
        chk("R5 call-rel sp", sp_out, 16'h00FC);
        @(negedge clk);
        chk("R5 saved pc rel", mem[8'h7E], 16'h0200);

        // R6 returns
        run_op(3'd4, 3'b000, 3'b000, 3'b000, 16'h0999, 16'h0, 16'h00FC, 16'h0, lat);
        chk("R6 return pc", pc_out, 16'h0200);
        chk("R6 return sp", sp_out, 16'h00FE);
        chk("R9 return latency", 16'(lat), 16'd4);
        chk("R6 return we", {14'd0, sp_we, dst_we}, 16'b10);
        run_op(3'd4, 3'b000, 3'b000, 3'b000, 16'h0999, 16'h0, 16'h00FE, 16'h0, lat);
        chk("R6 return2 pc", pc_out, 16'h0124);
        chk("R6 return2 sp", sp_out, 16'h0100);

        // R7 push / R8 pop
        run_op(3'd5, 3'b000, 3'b000, 3'b000, 16'h0300, 16'h0, 16'h0080, 16'hBEEF, lat);
        chk("R7 push sp", sp_out, 16'h007E);
        chk("R7 push pc", pc_out, 16'h0300);
        chk("R9 push latency", 16'(lat), 16'd3);
        @(negedge clk);
        chk("R7 pushed word", mem[8'h3F], 16'hBEEF);
        run_op(3'd6, 3'b000, 3'b000, 3'b000, 16'h0310, 16'h0, 16'h007E, 16'h0, lat);
        chk("R8 pop data", dst_data, 16'hBEEF);
        chk("R8 pop we", {14'd0, sp_we, dst_we}, 16'b11);
        chk("R8 pop sp", sp_out, 16'h0080);
        chk("R8 pop pc", pc_out, 16'h0310);
        chk("R12 pop latency", 16'(lat), 16'd4);

        // R11 wrap
        run_op(3'd5, 3'b000, 3'b000, 3'b000, 16'h0400, 16'h0, 16'h0000, 16'h1357, lat);
        chk("R11 wrap sp", sp_out, 16'hFFFE);
        @(negedge clk);
        chk("R11 wrap word", mem[8'hFF], 16'h1357);
        run_op(3'd6, 3'b000, 3'b000, 3'b000, 16'h0400, 16'h0, 16'hFFFE, 16'h0, lat);
        chk("R11 wrap pop", dst_data, 16'h1357);
        chk("R11 wrap pop sp", sp_out, 16'h0000);

        // R9 start ignored while busy
        @(negedge clk);
        op_class = 3'd2; care_mask = '0; want_flags = '0; flags = '0;
        pc_in = 16'h0600; imm = 16'h0A00; sp_in = 16'h0050; src_data = '0;
        start = 1'b1;
        @(negedge clk);
        op_class = 3'd0; imm = 16'h7777; sp_in = 16'h0010;
        dones = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                dones++;
                chk("R9 busy start pc", pc_out, 16'h0A00);
                chk("R9 busy start sp", sp_out, 16'h004E);
            end
        end
        chk("R9 single done", 16'(dones), 16'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule